// File: doc/BRIEF.md
# DMA Bus Tenure Limiter

This block stands between a DMA engine and the arbiter of a shared system bus. It decides when the engine may ask for the bus and how long it may keep it. It also enforces a rest period after each tenure. A 3-bit on-code sets the longest time the engine may own the bus, and one code value means "no limit". A 3-bit off-code sets the shortest time the engine must stay off the bus before it asks again, and one code value means "no rest".

The engine reports pending work and a transfer-done pulse. The arbiter returns a grant, and the bus reports whether a cycle is still in flight. The block raises a bus request toward the arbiter. It asserts a release signal toward the DMA datapath when the tenure has to end. The release completes only once the current bus cycle has finished; it never cuts a cycle short.

Both timers count microsecond ticks. A parameterised prescaler derives these ticks from the core clock. The prescaler restarts whenever a timer starts, so every interval is an exact number of clocks.

Top module: `dma_tenure_limiter`

## Requirements
- R1: `tenure_cfg[7:5]` holds the off-code and `tenure_cfg[4:2]` holds the on-code. Bits [1:0] have no effect.
- R2: From idle, a high `work_pending` raises `bus_req` on the next clock. The request stays high until a grant arrives. If `work_pending` falls before the grant, the request is withdrawn on the next clock.
- R3: A microsecond is exactly CLK_PER_US clocks. The tick prescaler restarts when a tenure or a rest begins, so N µs lasts exactly N*CLK_PER_US clocks.
- R4: On-codes 0 to 6 give a maximum tenure of 16, 32, 64, 128, 256, 512 or 1024 µs. The tenure starts on the clock after a grant is seen while requesting. `release_now` rises exactly when the tenure time has run out.
- R5: On-code 7 sets no time limit. The tenure ends only on a done pulse or when work runs out.
- R6: A `xfer_done` pulse during a tenure asserts `release_now` on the next clock, whatever on-time remains.
- R7: `work_pending` going low during a tenure asserts `release_now` on the next clock.
- R8: While `release_now` is high, `bus_req` is low. `release_now` stays high while `bus_busy` is high and drops on the clock after `bus_busy` is seen low.
- R9: Off-code 0 lets `bus_req` rise on the clock after the release ends. Off-codes 1 to 7 hold the request low for 16, 32, 64, 128, 256, 512 or 1024 µs after the release ends.
- R10: If `work_pending` is low when the rest ends, the block returns to idle and does not request.
- R11: While `rst_n` is low, `bus_req` and `release_now` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tenure_cfg | input | 8 | Off-code [7:5], on-code [4:2], [1:0] unused |
| work_pending | input | 1 | DMA engine has data left to move |
| xfer_done | input | 1 | One-clock pulse at the end of the transfer |
| bus_grant | input | 1 | Arbiter grants the bus |
| bus_busy | input | 1 | A bus cycle is still in flight |
| bus_req | output | 1 | Request to the arbiter, held through the tenure |
| release_now | output | 1 | Tells the datapath to leave the bus |

## Verification
The hardest situation to reach from the ports is a tenure that ends early at a chosen cycle. This can happen through a done pulse or through work running out, and it matters most when the unlimited on-code is selected, because the tenure then has no other way to end. The stimulus task arms the event at a chosen cycle count after the grant. It then holds the bus busy for a chosen number of clocks at the release. Every measured length is compared with the value the bench computes from the code tables and the prescaler ratio. Random runs mix grant delays, busy hold times, early-end modes and whether work remains.

// File: rtl/dma_tenure_limiter.sv
module dma_tenure_limiter #(
  parameter int CLK_PER_US = 100,
  parameter int BASE_US    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tenure_cfg,
  input  logic       work_pending,
  input  logic       xfer_done,
  input  logic       bus_grant,
  input  logic       bus_busy,
  output logic       bus_req,
  output logic       release_now
);
  localparam int PW = $clog2(CLK_PER_US + 1);
  localparam int TW = $clog2((BASE_US << 6) + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ON, S_REL, S_OFF} st_t;
  st_t st, st_nx;

  logic [PW-1:0] pre;
  logic [TW-1:0] tcnt;

  wire [2:0]    off_code  = tenure_cfg[7:5];
  wire [2:0]    on_code   = tenure_cfg[4:2];
  wire          unlimited = (on_code == 3'd7);
  wire [TW-1:0] on_lim    = TW'(BASE_US) << on_code;
  wire [TW-1:0] off_lim   = TW'(BASE_US / 2) << off_code;
  wire          tick      = (pre == PW'(CLK_PER_US - 1));
  wire          on_exp    = !unlimited && tick && (tcnt == on_lim - TW'(1));
  wire          off_exp   = tick && (tcnt == off_lim - TW'(1));
  wire          restart   = (st_nx != st) && (st_nx == S_ON || st_nx == S_OFF);

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (work_pending) st_nx = S_REQ;
      S_REQ:  if (!work_pending) st_nx = S_IDLE;
              else if (bus_grant) st_nx = S_ON;
      S_ON:   if (xfer_done || !work_pending || on_exp) st_nx = S_REL;
      S_REL:  if (!bus_busy) begin
                if (off_code != 3'd0) st_nx = S_OFF;
                else st_nx = work_pending ? S_REQ : S_IDLE;
              end
      S_OFF:  if (off_exp) st_nx = work_pending ? S_REQ : S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      tcnt <= '0;
    end else if (restart) begin
      pre  <= '0;
      tcnt <= '0;
    end else if (tick) begin
      pre  <= '0;
      tcnt <= tcnt + TW'(1);
    end else begin
      pre  <= pre + PW'(1);
    end
  end

  assign bus_req     = (st == S_REQ) || (st == S_ON);
  assign release_now = (st == S_REL);

  AST_REQ_REL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && release_now)); // R8
  AST_BUSY_HOLDS_REL: assert property (@(posedge clk) disable iff (!rst_n)
    release_now && bus_busy |=> release_now); // R8
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ON) && xfer_done |=> release_now); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && !work_pending |=> !bus_req); // R2
  AST_REST_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(release_now) && ($past(off_code) != 3'd0) |-> !bus_req); // R9
endmodule

// File: tb/tb_dma_tenure_limiter.sv
module tb_dma_tenure_limiter;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg = '0;
  logic       work = 1'b0, done = 1'b0, grant = 1'b0, busy = 1'b0;
  logic       bus_req, release_now;
  int         errs = 0, checks = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_tenure_limiter #(.CLK_PER_US(CPU), .BASE_US(16)) dut (
    .clk(clk), .rst_n(rst_n), .tenure_cfg(cfg), .work_pending(work),
    .xfer_done(done), .bus_grant(grant), .bus_busy(busy),
    .bus_req(bus_req), .release_now(release_now));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int on_us(bit [2:0] c);
    case (c)
      3'd0: return 16;   3'd1: return 32;  3'd2: return 64;
      3'd3: return 128;  3'd4: return 256; 3'd5: return 512;
      3'd6: return 1024; default: return 0;
    endcase
  endfunction

  function automatic int off_us(bit [2:0] c);
    case (c)
      3'd0: return 0;    3'd1: return 16;  3'd2: return 32;
      3'd3: return 64;   3'd4: return 128; 3'd5: return 256;
      3'd6: return 512;  default: return 1024;
    endcase
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // dmode: 0 runs to the time limit, 1 pulses done at cycle dn, 2 drops work at cycle dn
  task automatic tenure(bit [2:0] onc, bit [2:0] offc, int gd, int bd, int dn, int dmode, bit keep);
    int n, m, lim, exp_on;
    bit kp;
    string tag;
    kp = keep && (dmode != 2);
    cfg = {offc, onc, 2'($urandom)};
    work = 1'b1; grant = 1'b0; busy = 1'b0; done = 1'b0;
    @(negedge clk);
    chk("R2 request raised", int'(bus_req), 1);
    repeat (gd) @(negedge clk);
    if (gd > 0) chk("R2 request held without grant", int'(bus_req), 1);
    grant = 1'b1;
    n = 0;
    while (!release_now && n < 8000) begin
      if (dmode != 0 && n == dn) begin
        if (dmode == 1) done = 1'b1;
        else work = 1'b0;
      end
      @(negedge clk);
      done = 1'b0;
      n++;
    end
    lim = on_us(onc) * CPU;
    exp_on = (dmode != 0 && (onc == 3'd7 || dn < lim)) ? dn + 1 : lim + 1;
    tag = (dmode == 1) ? "R6" : (dmode == 2) ? "R7" : (onc == 3'd7) ? "R5" : "R4";
    chk($sformatf("%s R1 R3 tenure cycles on=%0d", tag, onc), n, exp_on);
    chk("R8 request low at release", int'(bus_req), 0);
    grant = 1'b0;
    if (bd > 0) busy = 1'b1;
    repeat (bd) begin
      @(negedge clk);
      chk("R8 release held while busy", int'(release_now), 1);
    end
    busy = 1'b0;
    work = kp;
    lim = off_us(offc) * CPU;
    m = 0;
    do begin
      @(negedge clk);
      m++;
      if (m == 1) chk("R8 release ends after busy drops", int'(release_now), 0);
    end while (!bus_req && m < lim + 20);
    if (kp) chk($sformatf("R9 R1 rest cycles off=%0d", offc), m, lim + 1);
    else    chk("R10 no request without work", int'(bus_req), 0);
    work = 1'b0;
    @(negedge clk);
    chk("R2 request withdrawn", int'(bus_req), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R11 bus_req in reset", int'(bus_req), 0);
    chk("R11 release_now in reset", int'(release_now), 0);
    rst_n = 1'b1;
    @(negedge clk);
    tenure(3'd0, 3'd0, 0, 0, 0, 0, 1'b1);
    tenure(3'd6, 3'd7, 2, 3, 0, 0, 1'b1);
    tenure(3'd7, 3'd1, 1, 1, 200, 1, 1'b1);
    tenure(3'd7, 3'd2, 0, 0, 50, 2, 1'b1);
    tenure(3'd2, 3'd3, 0, 2, 10, 1, 1'b0);
    tenure(3'd1, 3'd0, 0, 0, 0, 0, 1'b0);
    tenure(3'd0, 3'd1, 3, 0, 1, 1, 1'b1);
    for (int i = 0; i < 40; i++) begin
      tenure(3'($urandom_range(2, 0)), 3'($urandom_range(3, 0)),
             int'($urandom_range(4, 0)), int'($urandom_range(3, 0)),
             int'($urandom_range(150, 1)), int'($urandom_range(2, 0)),
             1'($urandom_range(1, 0)));
    end
    report();
  end
endmodule